// File: doc/BRIEF.md
# Multi-Source Reset Pulse Sequencer

This block merges five reset causes into a single active-low reset output. The causes are a power-on indication, a power-fail detect, an oscillator-fail detect, a watchdog timeout strobe and an external reset pin. Each cause produces a pulse of its own length:

- Power-on, power-fail and oscillator-fail are the long sources. Each holds the output low for a fixed count of clocks after the source goes away.
- A watchdog timeout holds the output low for a whole number of machine cycles.
- An external reset makes the output follow the pin, after a two-flop synchroniser.

The long sources always win. A long count restarts whenever one of them is seen, and no shorter event can cut it short.

A sticky cause register records every source that has been seen. Software reads it and clears chosen bits by pulsing a write-one-to-clear strobe. The block sits after the analog detectors and the watchdog counter, which deliver their signals as single-bit inputs in the block's clock domain. The external pin is the only asynchronous input.

Top module: `reset_pulse_sequencer`

## Requirements
- R1: While `rst` is high, `rst_n_o` is 0 and `cause_o` is 0. With no source active, `rst_n_o` is 1 from the first clock edge after `rst` falls.
- R2: Any cycle in which `por_i`, `pwr_fail_i` or `osc_fail_i` is sampled high drives `rst_n_o` to 0 from the next clock edge. The output then stays 0 for `LONG_CLKS` clocks (default 65536) after the last edge at which such a source was high.
- R3: A long source that arrives during a watchdog pulse, an external pulse or a running long count restarts the full `LONG_CLKS` count.
- R4: A watchdog strobe seen while the output is high drives `rst_n_o` to 0 for exactly `WDT_MCYC` machine cycles of `MC_CLKS` clocks each, that is 2 × 4 = 8 clocks at the defaults.
- R5: A watchdog strobe during a long count neither ends nor extends it. The output rises at the same edge it would have without the strobe.
- R6: The external pin passes through `SYNC_STAGES` flops (default 2). `rst_n_o` falls 3 clocks after the pin rises and rises 3 clocks after the pin falls, which is under 1.25 machine cycles at the defaults.
- R7: If the synchronised external pin is still high when a long or watchdog pulse ends, `rst_n_o` stays 0 until the pin falls.
- R8: The `cause_o` bits are sticky, with bit0 power-on, bit1 power-fail, bit2 oscillator-fail, bit3 watchdog and bit4 external (synchronised pin). Each bit sets one clock after its source is sampled high.
- R9: A 1 in `cause_clr_i[k]` clears `cause_o[k]` at the next edge. If the source of bit k is high in the same cycle, setting wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer state |
| ext_rst_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_tmo_i | input | 1 | Watchdog timeout strobe |
| osc_fail_i | input | 1 | Oscillator-fail detect, level |
| pwr_fail_i | input | 1 | Power-fail detect, level |
| por_i | input | 1 | Power-on indication, level |
| cause_clr_i | input | 5 | Write-one-to-clear strobe for the cause bits |
| rst_n_o | output | 1 | Active-low reset output |
| cause_o | output | 5 | Sticky latched reset causes |

## Verification
Several properties are checked on every cycle:
- A long source, or a watchdog strobe seen while idle, pulls the output low on the next edge.
- A running long count is never left early.
- A held synchronised external reset keeps the output low, and the output releases once that pin has fallen.
- Cause bits stay set unless cleared, appear after their source, and drop when cleared without a competing set.

The exact pulse lengths need the bench's scenarios, which measure them against a behavioural model. These cover the long count after a source falls, the eight-clock watchdog pulse and the three-clock synchroniser latency. The scenarios also cover the restart of a long count from within a watchdog pulse and an external pin held across the end of a long pulse.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_LONG = 2'd1,
        MODE_WDT  = 2'd2,
        MODE_EXT  = 2'd3
    } rsq_mode_e;

    // Packed so that por is bit 0 and ext is bit 4.
    typedef struct packed {
        logic ext;
        logic wdt;
        logic osc;
        logic pfail;
        logic por;
    } rsq_cause_t;

    function automatic logic is_long(rsq_cause_t s);
        return s.por | s.pfail | s.osc;
    endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_mcycle.sv
module rsq_mcycle #(
    parameter int MC_CLKS = 4,
    parameter int NUM_MC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic run_i,
    output logic done_o
);
    localparam int PW = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
    localparam int CW = (NUM_MC > 1) ? $clog2(NUM_MC) : 1;

    logic [PW-1:0] phase_q;
    logic [CW-1:0] mc_q;
    logic          tick;

    assign tick = (phase_q == PW'(MC_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            phase_q <= '0;
            mc_q    <= '0;
        end else if (run_i) begin
            if (tick) begin
                phase_q <= '0;
                mc_q    <= mc_q + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign done_o = run_i & tick & (mc_q == CW'(NUM_MC - 1));

    // The sequencer must leave the watchdog mode before the cycle count passes its limit.
    assert_mc_bound_R4: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (int'(mc_q) < NUM_MC));
endmodule

// File: rtl/rsq_cause.sv
module rsq_cause
    import rsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  rsq_cause_t         set_i,
    input  logic [CAUSE_W-1:0] clr_i,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] set_v;

    assign set_v = set_i;

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= (cause_q & ~clr_i) | set_v;
    end

    assign cause_o = cause_q;

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(cause_q & ~clr_i) & ~cause_q) == '0));
    assert_set_seen_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_v) & ~cause_q) == '0));
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(clr_i & ~set_v) & cause_q) == '0));
endmodule

// File: rtl/reset_pulse_sequencer.sv
module reset_pulse_sequencer
    import rsq_pkg::*;
#(
    parameter int LONG_CLKS   = 65536,
    parameter int MC_CLKS     = 4,
    parameter int WDT_MCYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_rst_i,
    input  logic               wdt_tmo_i,
    input  logic               osc_fail_i,
    input  logic               pwr_fail_i,
    input  logic               por_i,
    input  logic [CAUSE_W-1:0] cause_clr_i,
    output logic               rst_n_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int LW = (LONG_CLKS > 1) ? $clog2(LONG_CLKS) : 1;

    logic       ext_s;
    rsq_cause_t src;
    logic       long_lvl;
    rsq_mode_e  mode_q, mode_d;
    logic [LW-1:0] lcnt_q, lcnt_d;
    logic       rst_n_q;
    logic       mc_start, mc_done;

    rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ext_rst_i),
        .q_o (ext_s)
    );

    always_comb begin
        src.ext   = ext_s;
        src.wdt   = wdt_tmo_i;
        src.osc   = osc_fail_i;
        src.pfail = pwr_fail_i;
        src.por   = por_i;
    end

    assign long_lvl = is_long(src);

    rsq_mcycle #(.MC_CLKS(MC_CLKS), .NUM_MC(WDT_MCYC)) u_mcycle (
        .clk     (clk),
        .rst     (rst),
        .start_i (mc_start),
        .run_i   (mode_q == MODE_WDT),
        .done_o  (mc_done)
    );

    rsq_cause u_cause (
        .clk     (clk),
        .rst     (rst),
        .set_i   (src),
        .clr_i   (cause_clr_i),
        .cause_o (cause_o)
    );

    always_comb begin
        mode_d   = mode_q;
        lcnt_d   = lcnt_q;
        mc_start = 1'b0;
        if (long_lvl) begin
            mode_d = MODE_LONG;
            lcnt_d = LW'(LONG_CLKS - 1);
        end else begin
            unique case (mode_q)
                MODE_LONG: begin
                    if (lcnt_q == '0) mode_d = ext_s ? MODE_EXT : MODE_IDLE;
                    else              lcnt_d = lcnt_q - 1'b1;
                end
                MODE_WDT: begin
                    if (mc_done) mode_d = ext_s ? MODE_EXT : MODE_IDLE;
                end
                MODE_EXT: begin
                    if (!ext_s) begin
                        if (wdt_tmo_i) begin
                            mode_d   = MODE_WDT;
                            mc_start = 1'b1;
                        end else begin
                            mode_d = MODE_IDLE;
                        end
                    end
                end
                default: begin
                    if (wdt_tmo_i) begin
                        mode_d   = MODE_WDT;
                        mc_start = 1'b1;
                    end else if (ext_s) begin
                        mode_d = MODE_EXT;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_IDLE;
            lcnt_q  <= '0;
            rst_n_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            lcnt_q  <= lcnt_d;
            rst_n_q <= (mode_d == MODE_IDLE);
        end
    end

    assign rst_n_o = rst_n_q;

    assert_long_low_R2: assert property (@(posedge clk) disable iff (rst)
        long_lvl |=> !rst_n_o);
    assert_wdt_low_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_n_o && wdt_tmo_i) |=> !rst_n_o);
    assert_no_shorten_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_LONG && lcnt_q != '0) |=> (mode_q == MODE_LONG));
    assert_ext_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ext_s |=> !rst_n_o);
    assert_ext_release_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_EXT && !ext_s && !wdt_tmo_i && !long_lvl) |=> rst_n_o);
endmodule

// File: tb/reset_pulse_sequencer_test.sv
module reset_pulse_sequencer_test;
    localparam int L  = 40;
    localparam int MC = 4;
    localparam int W  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext = 1'b0, wdt = 1'b0, osc = 1'b0, pfail = 1'b0, por = 1'b0;
    logic [4:0] clr = '0;
    logic       rst_n_o;
    logic [4:0] cause_o;

    always #2 clk = ~clk;

    reset_pulse_sequencer #(.LONG_CLKS(L), .MC_CLKS(MC), .WDT_MCYC(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .ext_rst_i(ext), .wdt_tmo_i(wdt), .osc_fail_i(osc),
        .pwr_fail_i(pfail), .por_i(por), .cause_clr_i(clr),
        .rst_n_o(rst_n_o), .cause_o(cause_o)
    );

    int    total = 0, fails = 0, cyc = 0;
    string cur_req = "R1";
    bit    started = 0, finished = 0;

    // Behavioural reference
    int         long_rem = 0, wdt_rem = 0;
    bit         ext_on = 0, s1 = 0, s2 = 0, lng = 0, exp_n = 0;
    logic [4:0] exp_cause = '0;

    task automatic chk(string req, bit ok, string what, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            long_rem = 0; wdt_rem = 0; ext_on = 0; s1 = 0; s2 = 0;
            exp_cause = '0; exp_n = 0;
        end else begin
            lng = por | pfail | osc;
            if (lng) begin
                long_rem = L; wdt_rem = 0; ext_on = 0;
            end else if (long_rem > 0) begin
                long_rem--;
                if (long_rem == 0) ext_on = s2;
            end else if (wdt_rem > 0) begin
                wdt_rem--;
                if (wdt_rem == 0) ext_on = s2;
            end else if (ext_on) begin
                if (!s2) begin
                    ext_on = 0;
                    if (wdt) wdt_rem = W * MC;
                end
            end else begin
                if (wdt) wdt_rem = W * MC;
                else if (s2) ext_on = 1;
            end
            exp_cause = (exp_cause & ~clr) | {s2, wdt, osc, pfail, por};
            exp_n = !(long_rem > 0 || wdt_rem > 0 || ext_on);
            s2 = s1;
            s1 = ext;
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            cyc++;
            chk(cur_req, rst_n_o == exp_n, "rst_n_o vs model", int'(rst_n_o), int'(exp_n));
            chk(cur_req, cause_o == exp_cause, "cause_o vs model", int'(cause_o), int'(exp_cause));
            if (cyc > 20000) begin
                finished = 1;
                chk("watchdog", 1'b0, "run length", cyc, 20000);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    task automatic clear_all();
        @(negedge clk) clr = 5'h1f;
        @(negedge clk) clr = '0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!rst_n_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    int n;

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", rst_n_o == 1'b0, "rst_n_o in reset", int'(rst_n_o), 0);
        chk("R1", cause_o == 5'd0, "cause_o in reset", int'(cause_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", rst_n_o == 1'b1, "rst_n_o after reset", int'(rst_n_o), 1);

        // R2 power-on pulse
        cur_req = "R2";
        por = 1'b1;
        repeat (3) @(negedge clk);
        por = 1'b0;
        count_low(n);
        chk("R2", n == L, "low clocks after por", n, L);
        chk("R8", cause_o == 5'b00001, "cause after por", int'(cause_o), 1);
        clear_all();

        // R2 power-fail held
        pfail = 1'b1;
        repeat (10) @(negedge clk);
        pfail = 1'b0;
        count_low(n);
        chk("R2", n == L, "low clocks after power-fail", n, L);
        chk("R8", cause_o == 5'b00010, "cause after power-fail", int'(cause_o), 2);
        clear_all();

        // R2 oscillator fail
        osc = 1'b1;
        @(negedge clk) osc = 1'b0;
        count_low(n);
        chk("R2", n == L, "low clocks after osc-fail", n, L);
        chk("R8", cause_o == 5'b00100, "cause after osc-fail", int'(cause_o), 4);
        clear_all();

        // R4 watchdog pulse
        cur_req = "R4";
        repeat (3) @(negedge clk);
        wdt = 1'b1;
        @(negedge clk) wdt = 1'b0;
        count_low(n);
        chk("R4", n == W * MC, "watchdog pulse length", n, W * MC);
        chk("R8", cause_o == 5'b01000, "cause after watchdog", int'(cause_o), 8);
        clear_all();

        // R6 external pin
        cur_req = "R6";
        ext = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6", rst_n_o == 1'b1, "still high 2 clocks after pin", int'(rst_n_o), 1);
        repeat (8) @(negedge clk);
        ext = 1'b0;
        count_low(n);
        chk("R6", n == 3, "release delay after pin drop", n, 3);
        chk("R8", cause_o == 5'b10000, "cause after external", int'(cause_o), 16);
        clear_all();

        // R3 long source during watchdog pulse
        cur_req = "R3";
        repeat (2) @(negedge clk);
        wdt = 1'b1;
        @(negedge clk) wdt = 1'b0;
        repeat (3) @(negedge clk);
        por = 1'b1;
        @(negedge clk) por = 1'b0;
        count_low(n);
        chk("R3", n == L, "restarted long count", n, L);
        clear_all();

        // R3 long source restarting a running long count
        pfail = 1'b1;
        @(negedge clk) pfail = 1'b0;
        repeat (15) @(negedge clk);
        osc = 1'b1;
        @(negedge clk) osc = 1'b0;
        count_low(n);
        chk("R3", n == L, "long count restarted by second source", n, L);
        clear_all();

        // R5 watchdog during long count
        cur_req = "R5";
        por = 1'b1;
        @(negedge clk) por = 1'b0;
        n = 0;
        while (!rst_n_o && n < 1000) begin
            wdt = (n == 10);
            n++;
            @(negedge clk);
        end
        wdt = 1'b0;
        chk("R5", n == L, "long count with watchdog inside", n, L);
        clear_all();

        // R7 external pin held across end of long pulse
        cur_req = "R7";
        por = 1'b1;
        ext = 1'b1;
        @(negedge clk) por = 1'b0;
        repeat (L + 10) @(negedge clk);
        chk("R7", rst_n_o == 1'b0, "held by external past long end", int'(rst_n_o), 0);
        ext = 1'b0;
        count_low(n);
        chk("R7", n == 3, "release after external drop", n, 3);
        clear_all();

        // R9 set wins over simultaneous clear
        cur_req = "R9";
        pfail = 1'b1;
        repeat (2) @(negedge clk);
        clr = 5'h1f;
        @(negedge clk) clr = '0;
        chk("R9", cause_o == 5'b00010, "set beats clear", int'(cause_o), 2);
        pfail = 1'b0;
        count_low(n);
        clear_all();
        chk("R9", cause_o == 5'b00000, "cleared by strobe", int'(cause_o), 0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule